// File: doc/BRIEF.md
# NAND flash bus cycle sequencer

This block turns simple host accesses into timed bus cycles for a raw NAND device. The host reaches it through one request port. A two-bit window select picks one of four targets: the register bank, the command window, the address window or the data window. A write to the command window drives one byte with CLE high. A write to the address window drives one byte with ALE high. A read or a write to the data window runs a plain RE# or WE# cycle, either 8 or 16 bits wide.

Each device cycle passes through four phases: setup, strobe, hold and bus release. Each phase lasts a number of clocks taken from a timing register. There are two timing registers of the same layout. A per-request select chooses between the common-space set and the attribute-space set. A data read that directly follows a command or address cycle has its setup stretched by a programmed delay, one delay for each case. When wait-on-ready is enabled, a data read is held off while the device reports busy. The host request stays pending until the block acknowledges it.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset the control register reads 0x0001_FE00 (both RE delays at 15, every other bit 0) and both timing registers read 0xFFFF_FFFF. CE#, WE# and RE# are high and the bus is released.
- R2: The register window (host_win=0) maps control at 0x00, status at 0x04 (bit 0 = R/B# level), common timing at 0x08 and attribute timing at 0x0C; other offsets read 0. Only control bits 0-4, 6, 7 and 9-16 are stored: bit 1 is wait-on-ready, bit 2 bank enable, bit 4 16-bit width, 12:9 CLE-to-RE delay, 16:13 ALE-to-RE delay. A timing word holds setup in 7:0, strobe in 15:8, hold in 23:16 and release in 31:24.
- R3: A write to the command window (host_win=1) gives one WE# pulse with CLE high and ALE low. The byte is on dq[7:0] and the upper lane is 0. A read request to the command or address window is acknowledged with no device cycle.
- R4: A write to the address window (host_win=2) gives one WE# pulse with ALE high and CLE low, carrying the byte as in R3.
- R5: CE# is low for setup+1 clocks before the strobe falls. The strobe is low for strobe+1 clocks. CE# stays low for max(hold,1) clocks after the strobe rises. CE# is then high with the bus released for max(release,1) clocks, and the acknowledge comes in the last of these clocks.
- R6: On a write the bus is driven for every clock that CE# is low. On a read the bus is never driven.
- R7: A data-window read (host_win=3) pulses RE# and returns the bus value sampled at the end of the strobe. With the width bit set the value has 16 bits; with it clear the upper byte reads 0.
- R8: A data-window write drives all 16 bits when the width bit is set. It drives only the low byte, with the upper lane 0, when the width bit is clear.
- R9: host_attr=1 times the cycle from the attribute timing register and host_attr=0 from the common one.
- R10: A data read whose previous device cycle was a command gets CLE-to-RE extra setup clocks. After an address cycle it gets ALE-to-RE extra clocks. After a data cycle it gets none.
- R11: With bank enable clear, a device-window request is acknowledged in the clock it is presented and CE# never falls.
- R12: With wait-on-ready set, a data read does not start and is not acknowledged while R/B# is low; it starts on the clock after R/B# goes high. Writes are not held, and with the bit clear reads are not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Request, held until host_ack |
| host_we | input | 1 | 1 = write, 0 = read |
| host_win | input | 2 | 0 registers, 1 command, 2 address, 3 data |
| host_off | input | 5 | Byte offset within the register window |
| host_attr | input | 1 | Selects the attribute timing set |
| host_wdata | input | HOST_W | Write data |
| host_rdata | output | HOST_W | Read data, valid with host_ack |
| host_ack | output | 1 | Request done |
| nd_ce_n | output | 1 | Chip enable, active low |
| nd_cle | output | 1 | Command latch enable |
| nd_ale | output | 1 | Address latch enable |
| nd_we_n | output | 1 | Write strobe, active low |
| nd_re_n | output | 1 | Read strobe, active low |
| nd_dq_out | output | DQ_W | Bus value driven to the device |
| nd_dq_oe | output | 1 | Bus drive enable |
| nd_dq_in | input | DQ_W | Bus value from the device |
| nd_rb_n | input | 1 | Ready/busy, low = busy |

## Verification
The bench builds the block with DQ_W=16 and HOST_W=32. With these values the width bit selects either lane mode at run time, so the masking in both 8-bit and 16-bit operation can be checked. The bench programs small timing fields, including all-zero ones, to keep each phase short enough to count clock by clock. It loads the timing register that is not selected with a different value, so a wrong timing-set choice changes the measured phase lengths. Non-zero CLE-to-RE and ALE-to-RE delays place the extra setup clocks where the counts can observe them.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
   localparam int TF_W  = 8;
   localparam int DLY_W = 4;
   localparam int REG_W = 32;
   localparam int OFS_W = 5;

   localparam logic [OFS_W-1:0] OFS_CTRL = 5'h00;
   localparam logic [OFS_W-1:0] OFS_STAT = 5'h04;
   localparam logic [OFS_W-1:0] OFS_TCOM = 5'h08;
   localparam logic [OFS_W-1:0] OFS_TATT = 5'h0C;

   typedef enum logic [1:0] {
      WIN_REG = 2'd0,
      WIN_CMD = 2'd1,
      WIN_ADR = 2'd2,
      WIN_DAT = 2'd3
   } win_e;

   // msb first: release, hold, strobe, setup
   typedef struct packed {
      logic [TF_W-1:0] t_hiz;
      logic [TF_W-1:0] t_hold;
      logic [TF_W-1:0] t_strb;
      logic [TF_W-1:0] t_setup;
   } tim_t;

   typedef struct packed {
      logic [DLY_W-1:0] ale_re;
      logic [DLY_W-1:0] cle_re;
      logic             ecc_256;
      logic             ecc_on;
      logic             wide;
      logic             is_nand;
      logic             bank_en;
      logic             rdy_wait;
      logic             soft_rst;
   } ctrl_t;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_SETUP,
      SQ_STRB,
      SQ_HOLD,
      SQ_HIZ
   } sq_e;

   function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
      logic [REG_W-1:0] w;
      w       = '0;
      w[0]    = c.soft_rst;
      w[1]    = c.rdy_wait;
      w[2]    = c.bank_en;
      w[3]    = c.is_nand;
      w[4]    = c.wide;
      w[6]    = c.ecc_on;
      w[7]    = c.ecc_256;
      w[12:9] = c.cle_re;
      w[16:13] = c.ale_re;
      return w;
   endfunction

   function automatic ctrl_t word_to_ctrl(input logic [REG_W-1:0] w);
      ctrl_t c;
      c.soft_rst = w[0];
      c.rdy_wait = w[1];
      c.bank_en  = w[2];
      c.is_nand  = w[3];
      c.wide     = w[4];
      c.ecc_on   = w[6];
      c.ecc_256  = w[7];
      c.cle_re   = w[12:9];
      c.ale_re   = w[16:13];
      return c;
   endfunction
endpackage

// File: rtl/nfc_regs.sv
module nfc_regs
   import nfc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [OFS_W-1:0] ofs,
   input  logic [REG_W-1:0] wdata,
   input  logic             rb_n,
   output ctrl_t            ctrl,
   output tim_t             tim_com,
   output tim_t             tim_att,
   output logic [REG_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl        <= '0;
         ctrl.cle_re <= '1;
         ctrl.ale_re <= '1;
         tim_com     <= '1;
         tim_att     <= '1;
      end else if (wr_en) begin
         case (ofs)
            OFS_CTRL: ctrl    <= word_to_ctrl(wdata);
            OFS_TCOM: tim_com <= tim_t'(wdata);
            OFS_TATT: tim_att <= tim_t'(wdata);
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (ofs)
         OFS_CTRL: rdata = ctrl_to_word(ctrl);
         OFS_STAT: rdata = {{(REG_W-1){1'b0}}, rb_n};
         OFS_TCOM: rdata = REG_W'(tim_com);
         OFS_TATT: rdata = REG_W'(tim_att);
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/nfc_lane.sv
module nfc_lane #(
   parameter int DQ_W = 16
) (
   input  logic            wide,
   input  logic            byte_only,
   input  logic [DQ_W-1:0] wdata,
   input  logic [DQ_W-1:0] dq_in,
   output logic [DQ_W-1:0] wlane,
   output logic [DQ_W-1:0] rlane
);
   generate
      if (DQ_W == 16) begin : g_w16
         assign wlane = (wide && !byte_only) ? wdata : {8'h00, wdata[7:0]};
         assign rlane = wide ? dq_in : {8'h00, dq_in[7:0]};
      end else begin : g_w8
         logic unused_w8;
         assign wlane     = wdata;
         assign rlane     = dq_in;
         assign unused_w8 = wide ^ byte_only;
      end
   endgenerate
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
   import nfc_pkg::*;
#(
   parameter int DQ_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             we,
   input  win_e             kind,
   input  tim_t             tim,
   input  logic [DLY_W-1:0] cle_re,
   input  logic [DLY_W-1:0] ale_re,
   input  logic             bank_en,
   input  logic             rdy_wait,
   input  logic             rb_n,
   input  logic [DQ_W-1:0]  wlane,
   input  logic [DQ_W-1:0]  rlane,
   output logic             ce_n,
   output logic             cle,
   output logic             ale,
   output logic             we_n,
   output logic             re_n,
   output logic             dq_oe,
   output logic [DQ_W-1:0]  dq_out,
   output logic [DQ_W-1:0]  rd_data,
   output logic             dev_ack,
   output logic             idle
);
   localparam int CW = TF_W + 2;

   sq_e             st;
   logic [CW-1:0]   cnt;
   logic            we_q;
   win_e            kind_q;
   win_e            last_q;
   logic [DQ_W-1:0] dout_q;
   logic [DQ_W-1:0] rd_q;
   logic [DLY_W-1:0] extra;
   logic            dev_win, legal, stall, start, act;

   function automatic logic [CW-1:0] at_least_one(input logic [TF_W-1:0] v);
      return (v == '0) ? '0 : CW'(v) - CW'(1);
   endfunction

   always_comb begin
      extra = '0;
      if (!we && kind == WIN_DAT) begin
         case (last_q)
            WIN_CMD: extra = cle_re;
            WIN_ADR: extra = ale_re;
            default: extra = '0;
         endcase
      end
   end

   assign dev_win = req && (kind != WIN_REG);
   assign legal   = (kind == WIN_DAT) || we;
   assign stall   = rdy_wait && (kind == WIN_DAT) && !we && !rb_n;
   assign start   = (st == SQ_IDLE) && dev_win && bank_en && legal && !stall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         cnt    <= '0;
         we_q   <= 1'b0;
         kind_q <= WIN_DAT;
         last_q <= WIN_DAT;
         dout_q <= '0;
         rd_q   <= '0;
      end else begin
         case (st)
            SQ_IDLE: begin
               if (start) begin
                  st     <= SQ_SETUP;
                  cnt    <= CW'(tim.t_setup) + CW'(extra);
                  we_q   <= we;
                  kind_q <= kind;
                  last_q <= kind;
                  dout_q <= we ? wlane : '0;
               end
            end
            SQ_SETUP: begin
               if (cnt == '0) begin
                  st  <= SQ_STRB;
                  cnt <= CW'(tim.t_strb);
               end else begin
                  cnt <= cnt - CW'(1);
               end
            end
            SQ_STRB: begin
               if (cnt == '0) begin
                  st  <= SQ_HOLD;
                  cnt <= at_least_one(tim.t_hold);
                  if (!we_q) rd_q <= rlane;
               end else begin
                  cnt <= cnt - CW'(1);
               end
            end
            SQ_HOLD: begin
               if (cnt == '0) begin
                  st  <= SQ_HIZ;
                  cnt <= at_least_one(tim.t_hiz);
               end else begin
                  cnt <= cnt - CW'(1);
               end
            end
            SQ_HIZ: begin
               if (cnt == '0) st <= SQ_IDLE;
               else           cnt <= cnt - CW'(1);
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign act     = (st == SQ_SETUP) || (st == SQ_STRB) || (st == SQ_HOLD);
   assign ce_n    = !act;
   assign cle     = act && (kind_q == WIN_CMD);
   assign ale     = act && (kind_q == WIN_ADR);
   assign we_n    = !((st == SQ_STRB) && we_q);
   assign re_n    = !((st == SQ_STRB) && !we_q);
   assign dq_oe   = act && we_q;
   assign dq_out  = dout_q;
   assign rd_data = rd_q;
   assign idle    = (st == SQ_IDLE);
   assign dev_ack = ((st == SQ_HIZ) && (cnt == '0)) ||
                    ((st == SQ_IDLE) && dev_win && (!bank_en || !legal));
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
   import nfc_pkg::*;
#(
   parameter int DQ_W   = 16,
   parameter int HOST_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [1:0]        host_win,
   input  logic [OFS_W-1:0]  host_off,
   input  logic              host_attr,
   input  logic [HOST_W-1:0] host_wdata,
   output logic [HOST_W-1:0] host_rdata,
   output logic              host_ack,
   output logic              nd_ce_n,
   output logic              nd_cle,
   output logic              nd_ale,
   output logic              nd_we_n,
   output logic              nd_re_n,
   output logic [DQ_W-1:0]   nd_dq_out,
   output logic              nd_dq_oe,
   input  logic [DQ_W-1:0]   nd_dq_in,
   input  logic              nd_rb_n
);
   generate
      if (!(DQ_W == 8 || DQ_W == 16)) begin : g_bad_dq
         $error("nand_cycle_seq: DQ_W must be 8 or 16");
      end
      if (HOST_W != REG_W) begin : g_bad_host
         $error("nand_cycle_seq: HOST_W must equal the register width");
      end
   endgenerate

   win_e             win;
   ctrl_t            ctrl;
   tim_t             tim_com, tim_att, tim_sel;
   logic [REG_W-1:0] reg_rdata;
   logic [DQ_W-1:0]  wlane, rlane, rd_data;
   logic             reg_ack, dev_ack, seq_idle, bank_en, rdy_wait;
   logic             unused_ctrl;

   assign win         = win_e'(host_win);
   assign reg_ack     = host_req && (win == WIN_REG);
   assign tim_sel     = host_attr ? tim_att : tim_com;
   assign bank_en     = ctrl.bank_en;
   assign rdy_wait    = ctrl.rdy_wait;
   assign unused_ctrl = ^{ctrl.soft_rst, ctrl.is_nand, ctrl.ecc_on, ctrl.ecc_256};

   nfc_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_ack && host_we),
      .ofs     (host_off),
      .wdata   (host_wdata),
      .rb_n    (nd_rb_n),
      .ctrl    (ctrl),
      .tim_com (tim_com),
      .tim_att (tim_att),
      .rdata   (reg_rdata)
   );

   nfc_lane #(.DQ_W(DQ_W)) u_lane (
      .wide      (ctrl.wide),
      .byte_only (win != WIN_DAT),
      .wdata     (host_wdata[DQ_W-1:0]),
      .dq_in     (nd_dq_in),
      .wlane     (wlane),
      .rlane     (rlane)
   );

   nfc_seq #(.DQ_W(DQ_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (host_req),
      .we       (host_we),
      .kind     (win),
      .tim      (tim_sel),
      .cle_re   (ctrl.cle_re),
      .ale_re   (ctrl.ale_re),
      .bank_en  (bank_en),
      .rdy_wait (rdy_wait),
      .rb_n     (nd_rb_n),
      .wlane    (wlane),
      .rlane    (rlane),
      .ce_n     (nd_ce_n),
      .cle      (nd_cle),
      .ale      (nd_ale),
      .we_n     (nd_we_n),
      .re_n     (nd_re_n),
      .dq_oe    (nd_dq_oe),
      .dq_out   (nd_dq_out),
      .rd_data  (rd_data),
      .dev_ack  (dev_ack),
      .idle     (seq_idle)
   );

   assign host_ack   = reg_ack || dev_ack;
   assign host_rdata = (win == WIN_REG) ? reg_rdata :
                       (win == WIN_DAT) ? HOST_W'(rd_data) : '0;
endmodule

// File: rtl/nand_cycle_seq_chk.sv
module nand_cycle_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       host_req,
   input logic       host_we,
   input logic [1:0] host_win,
   input logic       host_ack,
   input logic       nd_ce_n,
   input logic       nd_cle,
   input logic       nd_ale,
   input logic       nd_we_n,
   input logic       nd_re_n,
   input logic       nd_dq_oe,
   input logic       nd_rb_n,
   input logic       bank_en,
   input logic       rdy_wait,
   input logic       seq_idle
);
   p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nd_we_n && !nd_re_n));

   p_latch_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(nd_cle && nd_ale));

   p_strobe_in_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!nd_we_n || !nd_re_n) |-> !nd_ce_n);

   p_hold_after_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nd_we_n) |-> !nd_ce_n);

   p_read_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !nd_re_n |-> !nd_dq_oe);

   p_ce_needs_bank_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nd_ce_n) |-> bank_en);

   p_busy_holds_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_idle && rdy_wait && bank_en && !nd_rb_n && host_req && !host_we &&
       host_win == 2'd3) |=> nd_ce_n);

   p_ack_after_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ack && host_win != 2'd0) |-> nd_ce_n);
endmodule

bind nand_cycle_seq nand_cycle_seq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .host_req (host_req),
   .host_we  (host_we),
   .host_win (host_win),
   .host_ack (host_ack),
   .nd_ce_n  (nd_ce_n),
   .nd_cle   (nd_cle),
   .nd_ale   (nd_ale),
   .nd_we_n  (nd_we_n),
   .nd_re_n  (nd_re_n),
   .nd_dq_oe (nd_dq_oe),
   .nd_rb_n  (nd_rb_n),
   .bank_en  (bank_en),
   .rdy_wait (rdy_wait),
   .seq_idle (seq_idle)
);

// File: tb/sim_nand_cycle_seq.sv
module sim_nand_cycle_seq;
   localparam int CLK_P = 10;
   localparam int DQ_W  = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_we = 1'b0, host_attr = 1'b0;
   logic [1:0]  host_win = 2'd0;
   logic [4:0]  host_off = 5'd0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_ack;
   logic        nd_ce_n, nd_cle, nd_ale, nd_we_n, nd_re_n, nd_dq_oe;
   logic [15:0] nd_dq_out;
   logic [15:0] nd_dq_in = '0;
   logic        nd_rb_n = 1'b1;

   always #(CLK_P/2) clk = ~clk;

   nand_cycle_seq #(.DQ_W(DQ_W), .HOST_W(32)) u0 (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
      .host_win(host_win), .host_off(host_off), .host_attr(host_attr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ack(host_ack),
      .nd_ce_n(nd_ce_n), .nd_cle(nd_cle), .nd_ale(nd_ale), .nd_we_n(nd_we_n),
      .nd_re_n(nd_re_n), .nd_dq_out(nd_dq_out), .nd_dq_oe(nd_dq_oe),
      .nd_dq_in(nd_dq_in), .nd_rb_n(nd_rb_n)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   task automatic check(input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [4:0] ofs, input logic [31:0] d);
      @(negedge clk);
      host_req = 1; host_we = 1; host_win = 2'd0; host_off = ofs; host_wdata = d;
      @(negedge clk);
      host_req = 0; host_we = 0;
   endtask

   task automatic reg_rd(input logic [4:0] ofs, output logic [31:0] d);
      @(negedge clk);
      host_req = 1; host_we = 0; host_win = 2'd0; host_off = ofs;
      @(negedge clk);
      d = host_rdata;
      host_req = 0;
   endtask

   int s_idle, s_pre, s_strb, s_post, s_hiz;
   bit saw_cle, saw_ale, saw_we, saw_re, oe_bad, acked;
   logic [15:0] dq_seen;
   logic [31:0] rd_seen;

   task automatic dev(input logic [1:0] win, input bit we, input bit attr,
                      input logic [15:0] d, input int rb_rel);
      bit seen_ce, seen_str;
      seen_ce = 0; seen_str = 0;
      s_idle = 0; s_pre = 0; s_strb = 0; s_post = 0; s_hiz = 0;
      saw_cle = 0; saw_ale = 0; saw_we = 0; saw_re = 0; oe_bad = 0; acked = 0;
      dq_seen = '0; rd_seen = '0;
      @(negedge clk);
      host_req = 1; host_we = we; host_win = win; host_attr = attr;
      host_wdata = {16'h0, d}; nd_dq_in = d;
      for (int i = 1; i <= 3000; i++) begin
         @(negedge clk);
         if (!nd_ce_n) begin
            seen_ce = 1;
            if (nd_cle) saw_cle = 1;
            if (nd_ale) saw_ale = 1;
            if (nd_dq_oe !== we) oe_bad = 1;
            if (!nd_we_n || !nd_re_n) begin
               seen_str = 1; s_strb++;
               if (!nd_we_n) saw_we = 1;
               if (!nd_re_n) saw_re = 1;
               dq_seen = nd_dq_out;
            end else if (!seen_str) s_pre++;
            else s_post++;
         end else begin
            if (nd_dq_oe) oe_bad = 1;
            if (seen_ce) s_hiz++;
            else s_idle++;
         end
         if (host_ack) begin
            acked = 1; rd_seen = host_rdata;
            break;
         end
         if (i == rb_rel) nd_rb_n = 1;
      end
      host_req = 0; host_we = 0; host_attr = 0;
   endtask

   // win, we, attr, setup, strobe, hold, release, data
   localparam logic [51:0] VEC [8] = '{
      {2'd1, 1'b1, 1'b0, 8'd3, 8'd2, 8'd1, 8'd2, 16'h1290},
      {2'd2, 1'b1, 1'b1, 8'd1, 8'd0, 8'd2, 8'd0, 16'hAB77},
      {2'd3, 1'b0, 1'b0, 8'd0, 8'd1, 8'd0, 8'd3, 16'hC3A5},
      {2'd1, 1'b1, 1'b1, 8'd0, 8'd0, 8'd0, 8'd0, 16'h00FF},
      {2'd3, 1'b0, 1'b1, 8'd2, 8'd4, 8'd1, 8'd1, 16'h5A0F},
      {2'd3, 1'b1, 1'b0, 8'd1, 8'd1, 8'd3, 8'd2, 16'hBEEF},
      {2'd3, 1'b0, 1'b0, 8'd1, 8'd0, 8'd1, 8'd1, 16'h1357},
      {2'd2, 1'b1, 1'b0, 8'd5, 8'd3, 8'd4, 8'd2, 16'h0012}
   };

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic [1:0]  prev;
      prev = 2'd3;

      // R1: reset state
      #(CLK_P * 3);
      @(negedge clk);
      check("R1", "ce_n idle", {31'b0, nd_ce_n}, 32'd1);
      check("R1", "we_n idle", {31'b0, nd_we_n}, 32'd1);
      check("R1", "re_n idle", {31'b0, nd_re_n}, 32'd1);
      check("R1", "bus released", {31'b0, nd_dq_oe}, 32'd0);
      rst_n = 1;
      reg_rd(5'h00, r); check("R1", "control reset", r, 32'h0001_FE00);
      reg_rd(5'h08, r); check("R1", "common timing reset", r, 32'hFFFF_FFFF);
      reg_rd(5'h0C, r); check("R1", "attribute timing reset", r, 32'hFFFF_FFFF);

      // R2: register map
      reg_wr(5'h00, 32'hFFFF_FFFF);
      reg_rd(5'h00, r); check("R2", "control writable mask", r, 32'h0001_FEDF);
      reg_wr(5'h08, 32'h1234_5678);
      reg_rd(5'h08, r); check("R2", "common timing rw", r, 32'h1234_5678);
      reg_rd(5'h14, r); check("R2", "unmapped offset", r, 32'h0);
      nd_rb_n = 0;
      reg_rd(5'h04, r); check("R2", "status busy", r, 32'h0);
      nd_rb_n = 1;
      reg_rd(5'h04, r); check("R2", "status ready", r, 32'h1);

      // enable, nand, 16-bit, CLE-to-RE 2, ALE-to-RE 3
      reg_wr(5'h00, 32'h0000_641C);

      // table: R3 R4 R5 R6 R7 R8 R9 R10
      foreach (VEC[k]) begin
         logic [1:0] w; bit we, at;
         logic [7:0] su, sb, ho, hz;
         logic [15:0] d;
         int extra;
         {w, we, at, su, sb, ho, hz, d} = VEC[k];
         reg_wr(at ? 5'h0C : 5'h08, {hz, ho, sb, su});
         reg_wr(at ? 5'h08 : 5'h0C, 32'h0909_0909);
         extra = 0;
         if (!we && w == 2'd3) extra = (prev == 2'd1) ? 2 : (prev == 2'd2) ? 3 : 0;
         prev = w;
         dev(w, we, at, d, -1);
         check("R5", "acked", {31'b0, acked}, 32'd1);
         check("R5/R9/R10", "setup clocks", s_pre, su + 1 + extra);
         check("R5/R9", "strobe clocks", s_strb, sb + 1);
         check("R5/R9", "hold clocks", s_post, (ho == 0) ? 1 : ho);
         check("R5/R9", "release clocks", s_hiz, (hz == 0) ? 1 : hz);
         check("R5", "no stall", s_idle, 0);
         check("R3", "cle", {31'b0, saw_cle}, {31'b0, w == 2'd1});
         check("R4", "ale", {31'b0, saw_ale}, {31'b0, w == 2'd2});
         check("R6", "bus drive", {31'b0, oe_bad}, 32'd0);
         check("R7", "re strobe", {31'b0, saw_re}, {31'b0, !we});
         check("R3", "we strobe", {31'b0, saw_we}, {31'b0, we});
         if (we) check("R8", "bus value", {16'h0, dq_seen},
                       (w == 2'd3) ? {16'h0, d} : {24'h0, d[7:0]});
         else    check("R7", "read data", rd_seen, {16'h0, d});
      end

      // R8 R7: 8-bit mode
      reg_wr(5'h00, 32'h0000_640C);
      reg_wr(5'h08, 32'h0101_0101);
      dev(2'd3, 1'b1, 1'b0, 16'hA55A, -1);
      check("R8", "8-bit write lane", {16'h0, dq_seen}, 32'h0000_005A);
      check("R5", "setup clocks 8-bit", s_pre, 2);
      dev(2'd3, 1'b0, 1'b0, 16'hBEEF, -1);
      check("R7", "8-bit read masked", rd_seen, 32'h0000_00EF);
      check("R10", "no extra after data", s_pre, 2);

      // R3: read request to command window
      dev(2'd1, 1'b0, 1'b0, 16'h0044, -1);
      check("R3", "cmd read acked", {31'b0, acked}, 32'd1);
      check("R3", "cmd read no cycle", s_pre + s_strb, 0);

      // R11: bank disabled
      reg_wr(5'h00, 32'h0000_0010);
      dev(2'd3, 1'b1, 1'b0, 16'h00AA, -1);
      check("R11", "disabled ack clocks", s_idle, 1);
      check("R11", "disabled no strobe", s_pre + s_strb + s_post, 0);

      // R12: wait-on-ready
      reg_wr(5'h00, 32'h0000_0006);
      nd_rb_n = 0;
      dev(2'd3, 1'b0, 1'b0, 16'h0033, 6);
      check("R12", "read held while busy", s_idle, 6);
      check("R12", "read after ready", rd_seen, 32'h0000_0033);
      nd_rb_n = 0;
      dev(2'd3, 1'b1, 1'b0, 16'h0066, -1);
      check("R12", "write not held", s_idle, 0);
      reg_wr(5'h00, 32'h0000_0004);
      dev(2'd3, 1'b0, 1'b0, 16'h0077, -1);
      check("R12", "read not held without enable", s_idle, 0);
      nd_rb_n = 1;

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule